// File: doc/BRIEF.md
# Page-Mode Row-Buffered Memory Controller

This controller connects a simple synchronous host request port to an external byte-wide parallel memory. That memory is arranged in rows of eight bytes. The host presents an address, a direction bit, write data and a valid strobe. A request is taken on any clock edge where both valid and ready are high. Read results come back on a separate response strobe, in the order the requests were taken. On the memory side the controller drives an active-low chip enable, the address, an active-low write enable, an active-low output enable and the write data bus.

The byte address is split into two fields. The upper bits name a row and the low three bits name a byte within that row. The first request to a row opens the row. Further requests to the same row that arrive on consecutive accept cycles run as page-mode cycles: chip enable stays low and no extra cycles are added. A request to another row, or a cycle in which the host offers nothing while a row is open, closes the row. Chip enable then goes high for a timed precharge. A high-speed mode adds one wait clock in front of the first access of each row and one extra precharge clock. Every row opening is counted in a saturating activation counter, so endurance use can be observed.

Top module: `pmc_ctrl`

## Requirements
- R1: The row is `addr[16:3]` and the byte-in-row is `addr[2:0]`. Requests taken on consecutive accept cycles that differ only in bits 2:0 run back-to-back with chip enable held low, and they count as a single activation.
- R2: While chip enable stays low, the row field of `mem_addr` never changes. A request to a different row is held, and it runs only after chip enable has been high for a full precharge.
- R3: If the host drives no valid request in a cycle where ready is high and a row is open, the row closes and a precharge follows. The next request then opens the row again, even when it is the same row.
- R4: A precharge lasts `max(cfg_pre_clks,1) + fast` clocks, where fast is 1 in high-speed mode and 0 otherwise. Chip enable is high and `req_ready` is low for the whole precharge.
- R5: In normal mode an eight-byte burst within one row takes 8 chip-enable-low clocks plus 1 precharge clock. In high-speed mode the first access of each row is preceded by one wait clock: chip enable is low, write enable and output enable are high, and ready is low. The burst then takes 9 chip-enable-low clocks plus 2 precharge clocks.
- R6: `cfg_fast` and `cfg_pre_clks` are captured only while `rst_n` is low. Changing them after reset has no effect on timing.
- R7: A write holds `mem_we_n` low for one clock per write, with `mem_addr` and `mem_dout` valid and `mem_ce_n` low. `mem_we_n` and `mem_oe_n` are never low in the same clock.
- R8: A read holds `mem_oe_n` low for one clock and samples `mem_din` at the end of that clock. `resp_valid` is high for the following clock, with that byte on `resp_rdata`.
- R9: `act_count` rises by exactly one for each row opening. It saturates at all ones and is cleared to zero by reset.
- R10: During and right after reset: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, `req_ready` is high, `resp_valid` is low and `act_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_fast | input | 1 | High-speed mode select (extra wait and precharge clock) |
| cfg_pre_clks | input | 4 | Base precharge length in clocks (0 treated as 1) |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address (row in 16:3, byte in 2:0) |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| resp_valid | output | 1 | Read data valid |
| resp_rdata | output | 8 | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 17 | Memory address |
| mem_dout | output | 8 | Data driven to memory on writes |
| mem_din | input | 8 | Data returned by memory on reads |
| act_count | output | CNT_W (32) | Saturating count of row openings |

## Verification
Some rules hold on every clock, and the embedded assertions check those. Write enable and output enable are never active together, and write enable never appears without chip enable. The row field stays stable while chip enable is low, and chip enable stays high for at least the configured precharge before it falls. A response always follows an output-enable clock. The activation counter only ever steps by one or holds at its maximum. Other properties depend on the whole sequence of requests, and only the bench scenarios can show them. These are the exact clock budgets of normal and high-speed bursts, closing a row on an idle cycle, the effect of configuration captured at reset, the total number of openings across a random request stream, and the correctness of data read back.

// File: rtl/pmc_pkg.sv
// Package: shared types for the page-mode memory controller.
// Assumes: nothing beyond a single clock domain.
package pmc_pkg;

    // Sequencer states: no row open, high-speed wait, data cycle, precharge.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_PRE  = 2'd3
    } pmc_state_t;

endpackage

// File: rtl/pmc_pre_timer.sv
// Module: pmc_pre_timer
// Counts down the precharge window. A start pulse loads len-1, and done is
// high in the last clock of the window.
// Assumes: len >= 1, and start is pulsed only while the previous window is over.
module pmc_pre_timer #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             done
);

    logic [LEN_W-1:0] remain_q;

    // Load the window on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= len - LEN_W'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - LEN_W'(1);
        end
    end

    assign done = (remain_q == '0);

endmodule

// File: rtl/pmc_act_counter.sv
// Module: pmc_act_counter
// Saturating count of row openings, used to observe endurance.
// Assumes: bump is a single-cycle pulse for each row opening.
module pmc_act_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;

    // Add one per opening and stick at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (bump && (count_q != CNT_MAX)) begin
            count_q <= count_q + CNT_ONE;
        end
    end

    assign count = count_q;

    // Once at the maximum, the count stays there.
    p_cnt_hold_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == CNT_MAX) |=> (count_q == CNT_MAX));

    // Any change of the count is a step of exactly one.
    p_cnt_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != $past(count_q)) |-> (count_q == $past(count_q) + CNT_ONE));

endmodule

// File: rtl/pmc_seq.sv
// Module: pmc_seq
// Request sequencer. It keeps track of the open row, runs page-mode cycles,
// holds a request to another row across the precharge, and drives the
// memory strobes.
// Assumes: the memory returns read data within the output-enable clock, and
// configuration is stable while rst_n is low.
module pmc_seq
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int PC_W   = 4,
    parameter int LEN_W  = PC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fast,
    input  logic [PC_W-1:0]   cfg_pre_clks,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic              pre_start,
    output logic [LEN_W-1:0]  pre_len,
    input  logic              pre_done,
    output logic              row_open
);

    localparam int RUN_W = LEN_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    pmc_state_t        state_q;
    logic              fast_q;
    logic [LEN_W-1:0]  pre_len_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic              cur_wr_q;
    logic [DATA_W-1:0] cur_wd_q;
    logic              pend_v_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_wr_q;
    logic [DATA_W-1:0] pend_wd_q;
    logic              resp_v_q;
    logic [DATA_W-1:0] resp_d_q;
    logic              accept;
    logic              same_row;
    pmc_state_t        open_state;

    // Capture the static configuration, but only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q    <= cfg_fast;
            pre_len_q <= ((cfg_pre_clks == '0) ? LEN_W'(1) : LEN_W'(cfg_pre_clks))
                         + LEN_W'(cfg_fast);
        end
    end

    // Decode the request against the open row.
    always_comb begin
        req_ready  = (state_q == ST_IDLE) || (state_q == ST_XFER);
        accept     = req_valid && req_ready;
        same_row   = (req_addr[ADDR_W-1:COL_W] == cur_addr_q[ADDR_W-1:COL_W]);
        open_state = fast_q ? ST_WAIT : ST_XFER;
        pre_start  = (state_q == ST_XFER) && !(accept && same_row);
        row_open   = ((state_q == ST_IDLE) && accept) ||
                     ((state_q == ST_PRE) && pre_done && pend_v_q);
        pre_len    = pre_len_q;
    end

    // Main sequence: open, page cycles, precharge, reopen a held request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_addr_q  <= '0;
            cur_wr_q    <= 1'b0;
            cur_wd_q    <= '0;
            pend_v_q    <= 1'b0;
            pend_addr_q <= '0;
            pend_wr_q   <= 1'b0;
            pend_wd_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cur_addr_q <= req_addr;
                        cur_wr_q   <= req_write;
                        cur_wd_q   <= req_wdata;
                        state_q    <= open_state;
                    end
                end
                ST_WAIT: begin
                    state_q <= ST_XFER;
                end
                ST_XFER: begin
                    if (accept && same_row) begin
                        cur_addr_q <= req_addr;
                        cur_wr_q   <= req_write;
                        cur_wd_q   <= req_wdata;
                    end else begin
                        state_q <= ST_PRE;
                        if (accept) begin
                            pend_v_q    <= 1'b1;
                            pend_addr_q <= req_addr;
                            pend_wr_q   <= req_write;
                            pend_wd_q   <= req_wdata;
                        end
                    end
                end
                default: begin
                    if (pre_done) begin
                        if (pend_v_q) begin
                            cur_addr_q <= pend_addr_q;
                            cur_wr_q   <= pend_wr_q;
                            cur_wd_q   <= pend_wd_q;
                            pend_v_q   <= 1'b0;
                            state_q    <= open_state;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Sample read data at the end of the output-enable clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_v_q <= 1'b0;
            resp_d_q <= '0;
        end else begin
            resp_v_q <= (state_q == ST_XFER) && !cur_wr_q;
            if ((state_q == ST_XFER) && !cur_wr_q) begin
                resp_d_q <= mem_din;
            end
        end
    end

    // Drive the memory strobes from the state and the current request.
    always_comb begin
        mem_ce_n   = !((state_q == ST_WAIT) || (state_q == ST_XFER));
        mem_we_n   = !((state_q == ST_XFER) && cur_wr_q);
        mem_oe_n   = !((state_q == ST_XFER) && !cur_wr_q);
        mem_addr   = cur_addr_q;
        mem_dout   = cur_wd_q;
        resp_valid = resp_v_q;
        resp_rdata = resp_d_q;
    end

    // Checker state: length of the current run of chip-enable-high clocks.
    logic [RUN_W-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= RUN_MAX;
        end else if (!mem_ce_n) begin
            hi_run_q <= '0;
        end else if (hi_run_q != RUN_MAX) begin
            hi_run_q <= hi_run_q + RUN_W'(1);
        end
    end

    p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    p_we_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    p_row_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |->
        (mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W])));

    p_pre_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (hi_run_q >= RUN_W'(pre_len_q)));

    p_ready_low_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> !req_ready);

    p_resp_after_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !$past(mem_oe_n));

endmodule

// File: rtl/pmc_ctrl.sv
// Module: pmc_ctrl (top)
// Page-mode row-buffered memory controller. It ties the sequencer, the
// precharge timer and the activation counter together.
// Assumes: a single clock and a synchronous active-low reset held for at
// least one clock edge.
module pmc_ctrl #(
    parameter int ADDR_W = 17,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int PC_W   = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_fast,
    input  logic [PC_W-1:0]   cfg_pre_clks,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din,
    output logic [CNT_W-1:0]  act_count
);

    localparam int LEN_W = PC_W + 1;

    logic             pre_start;
    logic [LEN_W-1:0] pre_len;
    logic             pre_done;
    logic             row_open;

    pmc_seq #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W),
        .PC_W   (PC_W),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_fast     (cfg_fast),
        .cfg_pre_clks (cfg_pre_clks),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .resp_valid   (resp_valid),
        .resp_rdata   (resp_rdata),
        .mem_ce_n     (mem_ce_n),
        .mem_we_n     (mem_we_n),
        .mem_oe_n     (mem_oe_n),
        .mem_addr     (mem_addr),
        .mem_dout     (mem_dout),
        .mem_din      (mem_din),
        .pre_start    (pre_start),
        .pre_len      (pre_len),
        .pre_done     (pre_done),
        .row_open     (row_open)
    );

    pmc_pre_timer #(
        .LEN_W (LEN_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pre_start),
        .len   (pre_len),
        .done  (pre_done)
    );

    pmc_act_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (row_open),
        .count (act_count)
    );

endmodule

// File: tb/sim_pmc_ctrl.sv
module sim_pmc_ctrl;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int CMAX = 255;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_fast = 1'b0;
    logic [3:0]    cfg_pre_clks = 4'd1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, mem_ce_n, mem_we_n, mem_oe_n;
    logic [DW-1:0] resp_rdata, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] act_count;

    always #5 clk = ~clk;

    pmc_ctrl #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .cfg_pre_clks(cfg_pre_clks),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_din(mem_din), .act_count(act_count)
    );

    // Memory model, aliased to 1 KiB; the bench reference aliases the same way.
    logic [DW-1:0] store [0:1023];
    logic [DW-1:0] refm  [0:1023];
    assign mem_din = store[mem_addr[9:0]];
    always @(posedge clk) if (!mem_ce_n && !mem_we_n) store[mem_addr[9:0]] <= mem_dout;

    int checks = 0;
    int errors = 0;
    int ce_lo = 0;
    int rdy_lo = 0;
    int pred_opens = 0;
    bit row_live = 0;
    logic [13:0] last_row = '0;
    logic [DW-1:0] expq [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: strobe counters and in-order read data (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) ce_lo++;
            if (!req_ready) rdy_lo++;
            if (resp_valid) begin
                if (expq.size() == 0) chk(0, "R8 unexpected response", resp_rdata, 0);
                else begin
                    logic [DW-1:0] e;
                    e = expq.pop_front();
                    chk(resp_rdata == e, "R8 read data", resp_rdata, e);
                end
            end
        end
    end

    function automatic int next_opens(input int cur);
        return (cur >= CMAX) ? CMAX : cur + 1;
    endfunction

    task automatic do_reset(input bit fast, input logic [3:0] pre);
        @(negedge clk);
        rst_n = 0; cfg_fast = fast; cfg_pre_clks = pre; req_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        pred_opens = 0; row_live = 0;
    endtask

    // Present one request; when gap is set, first leave one ready-high cycle empty.
    task automatic issue(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d, input bit gap);
        @(negedge clk);
        if (gap) begin
            req_valid = 0;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            row_live = 0;
        end
        if (!row_live || a[16:3] != last_row) pred_opens = next_opens(pred_opens);
        row_live = 1; last_row = a[16:3];
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (wr) refm[a[9:0]] = d;
        else expq.push_back(refm[a[9:0]]);
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        req_valid = 0;
        repeat (n) @(negedge clk);
        row_live = 0;
    endtask

    task automatic burst8(input logic [13:0] row);
        ce_lo = 0; rdy_lo = 0;
        for (int i = 0; i < 8; i++) issue({row, 3'(i)}, 1'b0, 8'h00, 1'b0);
        go_idle(8);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [CW-1:0] c0;
        logic [13:0] rows [4];
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            store[i] = 8'(i * 37 + 11);
            refm[i]  = 8'(i * 37 + 11);
        end

        // R10: reset state
        do_reset(1'b0, 4'd1);
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R10 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk(req_ready && !resp_valid, "R10 ready/resp", {req_ready, resp_valid}, 2);
        chk(act_count == 0, "R10 act_count", act_count, 0);

        // R7: single write strobe
        issue(17'h00010, 1'b1, 8'hA5, 1'b0);
        @(negedge clk);
        req_valid = 0;
        chk(!mem_we_n && mem_oe_n && !mem_ce_n, "R7 write strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 1);
        chk(mem_addr == 17'h00010 && mem_dout == 8'hA5, "R7 write addr/data", mem_dout, 8'hA5);
        @(negedge clk);
        chk(mem_we_n && mem_ce_n, "R7 write one clock", {mem_ce_n, mem_we_n}, 3);
        row_live = 0;

        // R8: read latency and data
        issue(17'h00010, 1'b0, 8'h00, 1'b1);
        @(negedge clk);
        req_valid = 0;
        chk(!mem_oe_n && mem_we_n, "R8 output enable", {mem_we_n, mem_oe_n}, 2);
        @(negedge clk);
        chk(resp_valid && resp_rdata == 8'hA5, "R8 response next clock", resp_rdata, 8'hA5);
        go_idle(6);

        // R1 R5: normal eight-byte burst
        c0 = act_count;
        burst8(14'h0123);
        chk(ce_lo == 8, "R5 normal ce-low clocks", ce_lo, 8);
        chk(rdy_lo == 1, "R5 normal precharge clocks", rdy_lo, 1);
        chk(act_count == c0 + 1, "R1 one activation per page burst", act_count, c0 + 1);

        // R2: row change back-to-back
        c0 = act_count; ce_lo = 0; rdy_lo = 0;
        issue(17'h01001, 1'b0, 8'h00, 1'b0);
        issue(17'h02002, 1'b0, 8'h00, 1'b0);
        go_idle(8);
        chk(act_count == c0 + 2, "R2 row change activations", act_count, c0 + 2);
        chk(rdy_lo == 2 && ce_lo == 2, "R2 precharge between rows", rdy_lo, 2);

        // R3: idle cycle closes the row
        c0 = act_count; rdy_lo = 0;
        issue(17'h03000, 1'b0, 8'h00, 1'b0);
        issue(17'h03001, 1'b0, 8'h00, 1'b1);
        go_idle(8);
        chk(act_count == c0 + 2, "R3 reopen after idle", act_count, c0 + 2);
        chk(rdy_lo == 2, "R3 two precharges", rdy_lo, 2);

        // R6: configuration changed after reset is ignored
        do_reset(1'b0, 4'd1);
        cfg_fast = 1; cfg_pre_clks = 4'd7;
        burst8(14'h0200);
        chk(ce_lo == 8 && rdy_lo == 1, "R6 config ignored after reset", rdy_lo, 1);
        cfg_fast = 0; cfg_pre_clks = 4'd1;

        // R5: high-speed burst
        do_reset(1'b1, 4'd1);
        burst8(14'h0300);
        chk(ce_lo == 9, "R5 fast ce-low clocks", ce_lo, 9);
        chk(rdy_lo == 3, "R5 fast wait+precharge clocks", rdy_lo, 3);

        // R4: precharge lengths
        do_reset(1'b0, 4'd3);
        ce_lo = 0; rdy_lo = 0;
        issue(17'h00100, 1'b0, 8'h00, 1'b0);
        go_idle(8);
        chk(rdy_lo == 3 && ce_lo == 1, "R4 precharge of 3", rdy_lo, 3);
        do_reset(1'b1, 4'd0);
        ce_lo = 0; rdy_lo = 0;
        issue(17'h00100, 1'b0, 8'h00, 1'b0);
        go_idle(8);
        chk(rdy_lo == 3 && ce_lo == 2, "R4 zero treated as one plus fast", rdy_lo, 3);

        // R1 R2 R9: random mix
        do_reset(1'b0, 4'd2);
        for (int i = 0; i < 4; i++) rows[i] = 14'($urandom());
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            a = {rows[$urandom_range(0, 3)], 3'($urandom())};
            issue(a, 1'($urandom()), 8'($urandom()), ($urandom_range(0, 3) == 0));
        end
        go_idle(10);
        chk(act_count == CW'(pred_opens), "R9 random activation count", act_count, pred_opens);
        chk(expq.size() == 0, "R8 all reads answered", expq.size(), 0);

        // R9: saturation, then clear on reset
        do_reset(1'b0, 4'd1);
        for (int i = 0; i < 270; i++) issue(17'(i * 8), 1'b0, 8'h00, 1'b1);
        go_idle(6);
        chk(act_count == CW'(CMAX), "R9 saturates", act_count, CMAX);
        do_reset(1'b0, 4'd1);
        @(negedge clk);
        chk(act_count == 0, "R9 cleared by reset", act_count, 0);

        finish_run();
    end

endmodule